// File: doc/BRIEF.md
# Clear-on-Read Interrupt Collector

This block gathers interrupt requests from a set of internal sources into a sticky pending register. It asserts an active-low, open-drain style interrupt line. The line is modelled here as a drive-low enable, so several devices can share one wired line. Each source has its own enable bit, and an event from a source whose enable is low is dropped. A set bit stays set until software reads it or a system reset arrives.

A read strobe captures the whole pending register into the read-data output. On the same clock edge it clears exactly the bits that were captured. An event that lands in the same cycle as the read is not part of the returned value, so it stays pending for the next read.

One source position is given to an over-temperature condition. A raised temperature always shows in a status output, whatever the enable bits are. It raises an interrupt only when its enable bit is high. It never blocks, clears or gates any other source or the read path.

Top module: `intr_cor_reg`

## Requirements
- R1: `irq_drive_low_o` is 1 exactly when at least one pending bit is set. It changes on the clock edge at which a bit is set or cleared.
- R2: A pending bit stays set across any number of cycles, whatever the events, enables or temperature do, until it is cleared by a read or a reset.
- R3: When `rd_stb_i` is 1 in a cycle, `rd_data_o` after that edge equals the pending register as it was before the edge. On the same edge every bit returned is cleared. `rd_data_o` holds that value until the next read.
- R4: An enabled event that arrives in the same cycle as a read is left out of the returned value and is pending after the edge.
- R5: A pulse on `evt_i[i]` while `en_i[i]` is 1 sets pending bit i (bit i belongs to source i, LSB is source 0) at the next edge.
- R6: A pulse on `evt_i[i]` while `en_i[i]` is 0 has no effect: bit i stays clear and the interrupt line is unaffected.
- R7: When `rst_n` is low at a clock edge, the pending register, `rd_data_o` and `temp_stat_o` all become 0.
- R8: `temp_stat_o` follows `temp_hot_i` one clock later, regardless of any enable bit.
- R9: A rising edge of `temp_hot_i` (low at the previous edge, high now) sets pending bit TEMP_IDX (default 0) only when `en_i[TEMP_IDX]` is 1. A level that stays high does not set the bit again after a read.
- R10: Over-temperature never clears, masks or blocks other pending bits, other sources or reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| evt_i | input | NUM_SRC | Per-source one-cycle event pulses |
| en_i | input | NUM_SRC | Per-source interrupt enables |
| temp_hot_i | input | 1 | Over-temperature condition level |
| rd_stb_i | input | 1 | Register read strobe (one cycle per access) |
| rd_data_o | output | NUM_SRC | Pending bits captured by the last read |
| irq_drive_low_o | output | 1 | 1 = pull the shared interrupt line low |
| temp_stat_o | output | 1 | Over-temperature status |

## Verification
The pending register and the interrupt line update on the first clock edge that samples an enabled event or a temperature rise. The read data and the clear take effect on the edge that samples the strobe, and the temperature status trails its input by one edge. All three results are due one edge after their stimulus. The bench therefore steps its reference model on each rising edge, using only the inputs it applied itself. It compares every output a fixed 1 ns after that edge, and changes inputs only at that point. Directed sequences cover the read-versus-event collision, disabled sources and held temperature levels. A long randomized phase then keeps the same per-edge comparison.

// File: rtl/intr_pkg.sv
// Package intr_pkg
// Shared constants and the per-bit next-state rule of the pending register.
// Assumes: callers apply the rule once per clock edge per bit.
package intr_pkg;

    // Default number of interrupt sources and over-temperature position.
    localparam int unsigned DEF_NUM_SRC  = 8;
    localparam int unsigned DEF_TEMP_IDX = 0;

    // Next value of one pending bit: a new set wins over a same-cycle clear.
    function automatic logic pend_next(input logic cur, input logic clr, input logic set);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/intr_temp_monitor.sv
// Module intr_temp_monitor
// Registers the over-temperature level as a status bit and reports a
// rising edge of it as a one-cycle request. Never drives any shutdown.
// Assumes: temp_hot_i is already synchronous to clk.
module intr_temp_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_hot_i,
    output logic temp_stat_o,
    output logic temp_rise_o
);

    logic temp_q;

    // Status register: follows the condition one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q <= 1'b0;
        end else begin
            temp_q <= temp_hot_i;
        end
    end

    // Rising-edge request: high now, low at the previous edge.
    always_comb begin
        temp_rise_o = temp_hot_i & ~temp_q;
    end

    assign temp_stat_o = temp_q;

endmodule

// File: rtl/intr_src_gate.sv
// Module intr_src_gate
// Qualifies each source event with its enable bit; the over-temperature
// rise request joins the source at TEMP_IDX before gating.
// Assumes: TEMP_IDX < NUM_SRC.
module intr_src_gate #(
    parameter int unsigned NUM_SRC  = 8,
    parameter int unsigned TEMP_IDX = 0
) (
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               temp_rise_i,
    output logic [NUM_SRC-1:0] set_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (g == TEMP_IDX) begin : g_temp
            // Temperature position: own event or temperature rise, gated.
            always_comb begin
                set_o[g] = (evt_i[g] | temp_rise_i) & en_i[g];
            end
        end else begin : g_plain
            // Ordinary position: event gated by its enable.
            always_comb begin
                set_o[g] = evt_i[g] & en_i[g];
            end
        end
    end

endmodule

// File: rtl/intr_pend_bank.sv
// Module intr_pend_bank
// One sticky flop per source. Set requests win over a same-cycle clear.
// Assumes: clr_i only carries bits that were pending when read.
module intr_pend_bank #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    import intr_pkg::*;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        logic pend_q;

        // Sticky pending flop for source g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
            end else begin
                pend_q <= pend_next(pend_q, clr_i[g], set_i[g]);
            end
        end

        assign pend_o[g] = pend_q;
    end

endmodule

// File: rtl/intr_read_port.sv
// Module intr_read_port
// Captures the pending register on a read strobe and requests a clear of
// exactly the captured bits on the same edge.
// Assumes: one strobe cycle per read access.
module intr_read_port #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_stb_i,
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [NUM_SRC-1:0] rd_data_o
);

    logic [NUM_SRC-1:0] snap_q;

    // Clear request: the bits being returned in this access.
    always_comb begin
        clr_o = rd_stb_i ? pend_i : '0;
    end

    // Snapshot register: holds the last returned value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (rd_stb_i) begin
            snap_q <= pend_i;
        end
    end

    assign rd_data_o = snap_q;

endmodule

// File: rtl/intr_cor_reg.sv
// Module intr_cor_reg (top)
// Clear-on-read interrupt collector with an open-drain style output
// modelled as a drive-low enable and an over-temperature source.
// Assumes: all inputs synchronous to clk; rst_n is the system reset.
module intr_cor_reg #(
    parameter int unsigned NUM_SRC  = intr_pkg::DEF_NUM_SRC,
    parameter int unsigned TEMP_IDX = intr_pkg::DEF_TEMP_IDX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               temp_hot_i,
    input  logic               rd_stb_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic               irq_drive_low_o,
    output logic               temp_stat_o
);

    logic               temp_rise;
    logic [NUM_SRC-1:0] set_req;
    logic [NUM_SRC-1:0] clr_req;
    logic [NUM_SRC-1:0] pend_q;

    intr_temp_monitor u_temp (
        .clk         (clk),
        .rst_n       (rst_n),
        .temp_hot_i  (temp_hot_i),
        .temp_stat_o (temp_stat_o),
        .temp_rise_o (temp_rise)
    );

    intr_src_gate #(.NUM_SRC(NUM_SRC), .TEMP_IDX(TEMP_IDX)) u_gate (
        .evt_i       (evt_i),
        .en_i        (en_i),
        .temp_rise_i (temp_rise),
        .set_o       (set_req)
    );

    intr_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_req),
        .clr_i  (clr_req),
        .pend_o (pend_q)
    );

    intr_read_port #(.NUM_SRC(NUM_SRC)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb_i  (rd_stb_i),
        .pend_i    (pend_q),
        .clr_o     (clr_req),
        .rd_data_o (rd_data_o)
    );

    // Line driver: pull low while any bit is pending.
    always_comb begin
        irq_drive_low_o = |pend_q;
    end

endmodule

// File: rtl/intr_cor_reg_chk.sv
// Module intr_cor_reg_chk
// Property checker bound to intr_cor_reg; observes ports and pending state.
module intr_cor_reg_chk #(
    parameter int unsigned NUM_SRC  = 8,
    parameter int unsigned TEMP_IDX = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt,
    input logic [NUM_SRC-1:0] en,
    input logic               temp_hot,
    input logic               rd_stb,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] rd_data,
    input logic               irq,
    input logic               temp_stat
);

    AST_READ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb && irq) |=> (rd_data != '0)); // R1
    AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n) rd_stb |=> (rd_data == $past(pend))); // R3
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!irq && rd_data == '0 && !temp_stat)); // R7
    AST_TEMP_STAT_HI: assert property (@(posedge clk) disable iff (!rst_n) temp_hot |=> temp_stat); // R8
    AST_TEMP_STAT_LO: assert property (@(posedge clk) disable iff (!rst_n) !temp_hot |=> !temp_stat); // R8
    AST_TEMP_RISE: assert property (@(posedge clk) disable iff (!rst_n) (en[TEMP_IDX] && temp_hot && !temp_stat) |=> pend[TEMP_IDX]); // R9

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (pend[g] && !rd_stb) |=> pend[g]); // R2
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb && evt[g] && en[g]) |=> pend[g]); // R4
        AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n) (evt[g] && en[g]) |=> pend[g]); // R5
        AST_DIS_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) (!pend[g] && !en[g]) |=> !pend[g]); // R6
        if (g != TEMP_IDX) begin : g_plain
            AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb && !(evt[g] && en[g])) |=> !pend[g]); // R3
        end
    end

endmodule

bind intr_cor_reg intr_cor_reg_chk #(.NUM_SRC(NUM_SRC), .TEMP_IDX(TEMP_IDX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt_i),
    .en        (en_i),
    .temp_hot  (temp_hot_i),
    .rd_stb    (rd_stb_i),
    .pend      (pend_q),
    .rd_data   (rd_data_o),
    .irq       (irq_drive_low_o),
    .temp_stat (temp_stat_o)
);

// File: tb/test_intr_cor_reg.sv
`timescale 1ns/1ps
module test_intr_cor_reg;

    localparam int N = 8;
    localparam int TI = 0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic [N-1:0] en = '0;
    logic         temp = 1'b0;
    logic         rd = 1'b0;
    logic [N-1:0] rd_data;
    logic         irq;
    logic         tstat;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Behavioural reference state
    bit m_pend[N];
    bit m_rd[N];
    bit m_tq;

    always #2.5 clk = ~clk;

    intr_cor_reg #(.NUM_SRC(N), .TEMP_IDX(TI)) i_intr_cor_reg (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_i(en),
        .temp_hot_i(temp), .rd_stb_i(rd), .rd_data_o(rd_data),
        .irq_drive_low_o(irq), .temp_stat_o(tstat)
    );

    function automatic logic [N-1:0] pack(input bit a[N]);
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i] = a[i];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one edge: update the model from applied inputs, compare after.
    task automatic step();
        bit any;
        bit rise;
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_rd[i] = 0; end
            m_tq = 0;
        end else begin
            rise = temp && !m_tq;
            for (int i = 0; i < N; i++) begin
                bit ev;
                ev = (evt[i] || (i == TI && rise)) && en[i];
                if (rd) m_rd[i] = m_pend[i];
                m_pend[i] = ev ? 1'b1 : (rd ? 1'b0 : m_pend[i]);
            end
            m_tq = temp;
        end
        #1;
        any = 0;
        for (int i = 0; i < N; i++) any |= m_pend[i];
        chk("R1 irq", N'(irq), N'(any));
        chk("R3 rd_data", rd_data, pack(m_rd));
        chk("R8 temp_stat", N'(tstat), N'(m_tq));
    endtask

    task automatic do_read(input string tag, input logic [N-1:0] exp);
        rd = 1; step(); rd = 0;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #100000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        chk("R7 reset irq", N'(irq), '0);
        chk("R7 reset data", rd_data, '0);
        rst_n = 1; en = '1; step();

        // R5: enabled source 3
        evt = 8'h08; step(); evt = '0;
        chk("R5 set bit3 irq", N'(irq), 1);
        // R6: source 5 disabled
        en[5] = 0; evt = 8'h20; step(); evt = '0; en[5] = 1;
        do_read("R6 R3 read", 8'h08);
        chk("R3 cleared irq", N'(irq), 0);
        do_read("R3 empty read", 8'h00);

        // R4: event in the read cycle survives
        evt = 8'h04; step(); evt = '0;
        evt = 8'h40; do_read("R4 read excludes new", 8'h04); evt = '0;
        chk("R4 irq stays", N'(irq), 1);
        do_read("R4 second read", 8'h40);

        // R2: sticky across idle cycles with enables off
        evt = 8'h02; step(); evt = '0; en = '0;
        for (int k = 0; k < 10; k++) step();
        chk("R2 still pending", N'(irq), 1);
        do_read("R2 read", 8'h02);

        // R9: temperature with interrupt disabled
        temp = 1; step(); step();
        chk("R8 status set", N'(tstat), 1);
        chk("R9 no irq when disabled", N'(irq), 0);
        temp = 0; step();
        // R10: other pending bit untouched by temperature
        en = '1; evt = 8'h10; step(); evt = '0;
        temp = 1; step(); step();
        do_read("R9 R10 read", 8'h11);
        step(); step();
        do_read("R9 held level no reset", 8'h00);
        temp = 0; step();

        // R7: reset with pending bits
        evt = 8'h81; step(); evt = '0;
        rst_n = 0; step(); rst_n = 1;
        chk("R7 mid reset irq", N'(irq), 0);
        chk("R7 mid reset data", rd_data, 0);

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            evt = N'($urandom); en = N'($urandom);
            rd = ($urandom % 4) == 0;
            if (($urandom % 8) == 0) temp = ~temp;
            rst_n = ($urandom % 300) != 0;
            step();
        end
        rst_n = 1; evt = '0; rd = 0; step();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule